// File: doc/BRIEF.md
# Page Write Buffer and Commit Unit

This block sits behind the serial front end of a small non-volatile byte memory of 512 eight-bit words. A sequence opens with a load-start strobe that carries a 9-bit word address. Each data byte that follows goes into a 16-entry page buffer, at the slot named by the low four address bits. That in-page pointer then steps forward and wraps inside the same 16-byte row. A loaded-slot mask records which slots received data.

A stop strobe closes the sequence. If at least one byte was loaded and write protect is low, the unit enters a timed commit of `WR_CYCLES` clock cycles and raises `busy_o`. During the first 16 cycles of the commit it scans the slots in ascending order and pulses an array write for each loaded slot. Slots that were not loaded are left alone. Every strobe is ignored while the commit runs. The storage array is modelled as a register array, and a combinational look port lets its contents be observed.

Top module: `page_commit_buf`

## Requirements
- R1: After reset, `busy_o` and `mem_we_o` are low.
- R2: After a start with address A, the i-th byte lands at array address {A[8:4], (A[3:0]+i) mod 16}. Only the low four bits advance, so the row never changes.
- R3: When more than 16 bytes arrive in one sequence, a later byte replaces the earlier byte in the same slot, and only the last value is committed.
- R4: A stop that follows at least one byte, with `wp_i` low, raises `busy_o` from the next cycle for exactly `WR_CYCLES` cycles, then `busy_o` falls.
- R5: In busy cycle k, counted from 0, `mem_we_o` is high exactly when k < 16 and slot k was loaded. In that cycle `mem_addr_o` = {row, k} and `mem_data_o` is the slot's byte. No other cycle writes, and afterwards the array holds those bytes.
- R6: A stop with `wp_i` high leaves `busy_o` low, writes nothing and discards the buffered bytes.
- R7: A stop after a start that had no bytes leaves `busy_o` low and writes nothing.
- R8: Start, byte and stop strobes during busy have no effect: committed data is unchanged, and after busy ends a sequence must begin with a new start.
- R9: Bytes and stops that arrive with no open sequence (no start since the last stop or commit) are ignored.
- R10: A second start before a stop discards the bytes loaded so far, and only bytes after the new start are committed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start_i | input | 1 | Opens a sequence and loads the start address |
| start_addr_i | input | 9 | Word address of the first byte |
| byte_vld_i | input | 1 | Data byte strobe |
| byte_i | input | 8 | Data byte |
| stop_i | input | 1 | Closes the sequence |
| wp_i | input | 1 | Write protect level, sampled with stop |
| look_addr_i | input | 9 | Observation address into the array |
| look_data_o | output | 8 | Array contents at `look_addr_i` |
| busy_o | output | 1 | Commit cycle in progress |
| mem_we_o | output | 1 | Array write strobe |
| mem_addr_o | output | 9 | Array write address |
| mem_data_o | output | 8 | Array write data |

## Verification
The assertions assume that at most one of start, byte and stop is asserted in any cycle, as the serial front end guarantees. The unit resolves a collision (stop wins over start, start over byte), but the properties are not phrased around one. Between busy periods the stimulus presents one strobe per cycle. Random multi-strobe noise, including `wp_i` changes, is applied only while `busy_o` is high, because every input is meant to be dead in that window.

// File: rtl/page_commit_buf.sv
module page_commit_buf #(
  parameter int AW        = 9,
  parameter int PW        = 4,
  parameter int DW        = 8,
  parameter int WR_CYCLES = 625000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [AW-1:0] start_addr_i,
  input  logic          byte_vld_i,
  input  logic [DW-1:0] byte_i,
  input  logic          stop_i,
  input  logic          wp_i,
  input  logic [AW-1:0] look_addr_i,
  output logic [DW-1:0] look_data_o,
  output logic          busy_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_data_o
);
  localparam int NSLOT = 1 << PW;
  localparam int DEPTH = 1 << AW;
  localparam int UW    = AW - PW;
  localparam int CW    = $clog2(WR_CYCLES + 1);

  logic [DW-1:0]    pbuf [NSLOT];
  logic [DW-1:0]    mem  [DEPTH];
  logic [NSLOT-1:0] mask;
  logic [UW-1:0]    row;
  logic [PW-1:0]    ptr;
  logic             armed;
  logic [CW-1:0]    cnt;
  logic [PW-1:0]    slot;

  wire take_stop  = !busy_o && armed && stop_i;
  wire commit     = take_stop && (|mask) && !wp_i;
  wire take_start = !busy_o && start_i && !stop_i;
  wire take_byte  = !busy_o && armed && byte_vld_i && !start_i && !stop_i;
  wire last_cyc   = (cnt == CW'(WR_CYCLES - 1));

  assign slot        = cnt[PW-1:0];
  assign mem_we_o    = busy_o && (cnt < CW'(NSLOT)) && mask[slot];
  assign mem_addr_o  = {row, slot};
  assign mem_data_o  = pbuf[slot];
  assign look_data_o = mem[look_addr_i];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_o <= 1'b0;
      armed  <= 1'b0;
      mask   <= '0;
      cnt    <= '0;
      row    <= '0;
      ptr    <= '0;
    end else if (busy_o) begin
      cnt <= cnt + 1'b1;
      if (last_cyc) begin
        busy_o <= 1'b0;
        mask   <= '0;
        cnt    <= '0;
      end
    end else if (take_stop) begin
      armed <= 1'b0;
      cnt   <= '0;
      if (commit) busy_o <= 1'b1;
      else        mask   <= '0;
    end else if (take_start) begin
      armed <= 1'b1;
      row   <= start_addr_i[AW-1:PW];
      ptr   <= start_addr_i[PW-1:0];
      mask  <= '0;
    end else if (take_byte) begin
      mask[ptr] <= 1'b1;
      ptr       <= ptr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (take_byte) pbuf[ptr] <= byte_i;
  end

  always_ff @(posedge clk) begin
    if (mem_we_o) mem[mem_addr_o] <= mem_data_o;
  end

  // R4
  busy_from_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> ($past(stop_i) && !$past(wp_i)));
  // R6
  wp_no_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_i && wp_i && !busy_o) |=> !busy_o);
  // R5
  row_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> $stable(mem_addr_o[AW-1:PW]));
  // R8
  mask_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> (mask == '0));
  // R9
  unarmed_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && !busy_o) |=> (mask == '0));
endmodule

// File: tb/page_commit_buf_tb.sv
module page_commit_buf_tb;
  localparam int W = 24;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start_i = 0, byte_vld_i = 0, stop_i = 0, wp_i = 0;
  logic [8:0] start_addr_i = '0, look_addr_i = '0;
  logic [7:0] byte_i = '0;
  logic [7:0] look_data_o, mem_data_o;
  logic [8:0] mem_addr_o;
  logic busy_o, mem_we_o;

  logic [7:0] em [512];
  bit         kn [512];
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  page_commit_buf #(.WR_CYCLES(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_addr_i(start_addr_i),
    .byte_vld_i(byte_vld_i), .byte_i(byte_i), .stop_i(stop_i), .wp_i(wp_i),
    .look_addr_i(look_addr_i), .look_data_o(look_data_o), .busy_o(busy_o),
    .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o), .mem_data_o(mem_data_o));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic drive(input bit st, input logic [8:0] a, input bit bv,
                       input logic [7:0] d, input bit sp, input bit wp);
    @(negedge clk);
    start_i = st; start_addr_i = a; byte_vld_i = bv; byte_i = d; stop_i = sp; wp_i = wp;
  endtask

  function automatic logic [3:0] slot_of(input logic [8:0] a, input int i);
    return 4'((int'(a[3:0]) + i) % 16);
  endfunction

  task automatic check_page(input logic [8:0] a, input string req);
    for (int s = 0; s < 16; s++) begin
      logic [8:0] ad;
      ad = {a[8:4], 4'(s)};
      if (kn[ad]) begin
        look_addr_i = ad;
        #1;
        chk(look_data_o == em[ad], req, look_data_o, em[ad]);
      end
    end
  endtask

  task automatic run_seq(input logic [8:0] a, input int n, input bit wp,
                         input bit noise, input bit with_start, input string req);
    logic [7:0] sb [16];
    bit sm [16];
    bit any;
    for (int s = 0; s < 16; s++) begin sm[s] = 0; sb[s] = '0; end
    if (with_start) drive(1, a, 0, 0, 0, 0);
    for (int i = 0; i < n; i++) begin
      logic [7:0] d;
      d = 8'($urandom);
      drive(0, a, 1, d, 0, 0);
      if (with_start) begin sm[slot_of(a, i)] = 1; sb[slot_of(a, i)] = d; end
    end
    drive(0, a, 0, 0, 1, wp);
    any = 0;
    for (int s = 0; s < 16; s++) any |= sm[s];
    drive(0, 0, 0, 0, 0, 0);
    if (with_start && any && !wp) begin
      for (int k = 0; k < W; k++) begin
        bit ew;
        ew = (k < 16) && sm[k];
        chk(busy_o == 1'b1, "R4", busy_o, 1);
        chk(mem_we_o == ew, "R5", mem_we_o, ew);
        if (ew) begin
          chk(mem_addr_o == {a[8:4], 4'(k)}, "R2", mem_addr_o, {a[8:4], 4'(k)});
          chk(mem_data_o == sb[k], (n > 16) ? "R3" : "R5", mem_data_o, sb[k]);
          em[{a[8:4], 4'(k)}] = sb[k];
          kn[{a[8:4], 4'(k)}] = 1;
        end
        if (noise)
          drive(1'($urandom), 9'($urandom), 1'($urandom), 8'($urandom),
                1'($urandom), 1'($urandom));
        else
          @(negedge clk);
      end
      start_i = 0; byte_vld_i = 0; stop_i = 0; wp_i = 0;
      chk(busy_o == 1'b0, "R4", busy_o, 0);
    end else begin
      for (int k = 0; k < 4; k++) begin
        chk(busy_o == 1'b0 && mem_we_o == 1'b0, req, {busy_o, mem_we_o}, 0);
        @(negedge clk);
      end
    end
    check_page(a, with_start && any && !wp ? "R5" : req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 512; i++) kn[i] = 0;
    repeat (3) @(negedge clk);
    chk(busy_o == 0 && mem_we_o == 0, "R1", {busy_o, mem_we_o}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(busy_o == 0 && mem_we_o == 0, "R1", {busy_o, mem_we_o}, 0);

    run_seq(9'h1A0, 16, 0, 0, 1, "R5");
    run_seq(9'h0FE, 3, 0, 0, 1, "R2");
    run_seq(9'h155, 20, 0, 0, 1, "R3");
    run_seq(9'h1A3, 5, 1, 0, 1, "R6");
    run_seq(9'h1A0, 0, 1, 0, 0, "R6");
    run_seq(9'h040, 0, 0, 0, 1, "R7");
    run_seq(9'h080, 4, 0, 0, 0, "R9");
    run_seq(9'h0C7, 6, 0, 1, 1, "R8");
    run_seq(9'h0C0, 5, 0, 0, 0, "R8");
    drive(1, 9'h1E2, 0, 0, 0, 0);
    for (int i = 0; i < 3; i++) drive(0, 9'h1E2, 1, 8'($urandom), 0, 0);
    run_seq(9'h129, 2, 0, 0, 1, "R10");
    check_page(9'h1E2, "R10");

    for (int it = 0; it < 40; it++)
      run_seq(9'($urandom), int'($urandom % 21), ($urandom % 4) == 0,
              1'($urandom), 1, "R7");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule